// File: doc/BRIEF.md
# I2C Slave Register Write Port

This block is an I2C bus slave that accepts write transfers only. It runs on a fast system clock and oversamples the SCL and SDA lines through synchronizers, then finds the bus conditions and clock edges in the system clock domain. A transfer opens with a START condition. A device byte follows, carrying a fixed 7-bit address and a direction bit. A register sub-address byte comes next, and then any number of data bytes. The block forwards each data byte to a register file through a single-cycle write strobe, together with the register address and the data.

The block acknowledges a byte by pulling SDA low through an open-drain output enable during the ninth SCL pulse. A device byte that carries another address, or that asks for a read, gets no acknowledge. In that case the slave stays off the bus until the next START. Within one transfer, the register address steps by one after every data byte, so a burst can begin at any register and runs on with 8-bit wrap-around.

Top module: `i2c_reg_writer`

## Requirements
- R1: After reset, sda_oe_o is 0, reg_we_o is 0, and reg_addr_o and reg_data_o are 0.
- R2: A falling SDA while SCL is high (START) opens an address phase from any state. A rising SDA while SCL is high (STOP) ends the transfer. After a STOP, bytes clocked in without a new START are neither acknowledged nor written.
- R3: A device byte, sent MSB first, whose upper seven bits are 1000011 and whose LSB (direction) is 0 is acknowledged. sda_oe_o is 1 from the SCL fall after the eighth bit until the SCL fall after the ninth pulse.
- R4: A device byte with any other 7-bit address is not acknowledged. Later bytes up to the next START are neither acknowledged nor written.
- R5: A device byte with the correct address and direction bit 1 (read) is not acknowledged, and the slave ignores the bus until the next START.
- R6: The byte that follows an acknowledged device byte is acknowledged and loaded as the register pointer. It causes no register write.
- R7: Each following data byte is acknowledged and produces exactly one clock cycle of reg_we_o = 1. During that cycle, reg_addr_o holds the current pointer and reg_data_o holds the byte, with the first bit received as bit 7.
- R8: After each data byte, the pointer increments by one and wraps from 0xFF to 0x00.
- R9: A START inside a transfer (repeated START) restarts the address phase. The following sub-address byte replaces the pointer.
- R10: A STOP that arrives before all eight bits of a data byte discards the partial byte, and no write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| reg_addr_o | output | 8 | Register address of the current write |
| reg_data_o | output | 8 | Register data of the current write |
| reg_we_o | output | 1 | Single-cycle write strobe |

## Verification
Most faults in the state or bit counter show up at the next acknowledge slot. There, the line seen by the master is high where a low is expected, or the reverse, within nine SCL pulses of the fault. A wrong pointer or shift register shows up at the next write strobe as a wrong address or wrong data. A wrong step in the pointer shows up on the second byte of a burst, and a missed wrap shows up only when a burst crosses 0xFF. A failure to clear on STOP or on a repeated START shows up in the following transfer as an extra acknowledge or a stray write.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DEV  = 2'd1,
    ST_SUB  = 2'd2,
    ST_DATA = 2'd3
  } wr_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = sync_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_lvl_i,
  input  logic scl_rise_i,
  input  logic scl_fall_i,
  input  logic sda_lvl_i,
  input  logic sda_rise_i,
  input  logic sda_fall_i,
  output logic start_o,
  output logic stop_o,
  output logic bit_rise_o,
  output logic bit_fall_o,
  output logic bit_val_o
);
  logic scl_steady_hi;
  logic start_q, stop_q, rise_q, fall_q, bit_q;

  // SDA edge only counts as a condition if SCL was high before and after
  assign scl_steady_hi = scl_lvl_i & ~scl_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
      bit_q   <= 1'b1;
    end else begin
      start_q <= scl_steady_hi & sda_fall_i;
      stop_q  <= scl_steady_hi & sda_rise_i;
      rise_q  <= scl_rise_i;
      fall_q  <= scl_fall_i;
      if (scl_rise_i) bit_q <= sda_lvl_i;
    end
  end

  assign start_o    = start_q;
  assign stop_o     = stop_q;
  assign bit_rise_o = rise_q;
  assign bit_fall_o = fall_q;
  assign bit_val_o  = bit_q;

  // R2
  cond_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_q || stop_q) |-> !(rise_q || fall_q));
endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
  import i2c_wr_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'b1000011,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              bit_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              wr_en_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  wr_state_e         state_q, after_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] shift_q;
  logic              ack_phase_q;
  logic              oe_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              we_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [BYTE_W-1:0] wr_data_q;
  logic              dev_hit;
  logic              byte_done;

  assign dev_hit   = (shift_q[BYTE_W-1:1] == DEV_ADDR) && !shift_q[0];
  assign byte_done = (bit_cnt_q == LAST_BIT) && !ack_phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      after_q     <= ST_IDLE;
      bit_cnt_q   <= '0;
      shift_q     <= '0;
      ack_phase_q <= 1'b0;
      oe_q        <= 1'b0;
      ptr_q       <= '0;
      we_q        <= 1'b0;
      wr_addr_q   <= '0;
      wr_data_q   <= '0;
    end else begin
      we_q <= 1'b0;
      if (start_i || stop_i) begin
        state_q     <= start_i ? ST_DEV : ST_IDLE;
        bit_cnt_q   <= '0;
        ack_phase_q <= 1'b0;
        oe_q        <= 1'b0;
      end else if (state_q != ST_IDLE) begin
        if (rise_i && !ack_phase_q && bit_cnt_q < LAST_BIT) begin
          shift_q   <= {shift_q[BYTE_W-2:0], bit_i};
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end else if (fall_i && byte_done) begin
          ack_phase_q <= 1'b1;
          unique case (state_q)
            ST_DEV: begin
              if (dev_hit) begin
                oe_q    <= 1'b1;
                after_q <= ST_SUB;
              end else begin
                // foreign address or read request: stay off the bus
                state_q     <= ST_IDLE;
                ack_phase_q <= 1'b0;
                bit_cnt_q   <= '0;
              end
            end
            ST_SUB: begin
              oe_q    <= 1'b1;
              ptr_q   <= shift_q[ADDR_W-1:0];
              after_q <= ST_DATA;
            end
            default: begin
              oe_q      <= 1'b1;
              we_q      <= 1'b1;
              wr_addr_q <= ptr_q;
              wr_data_q <= shift_q;
              ptr_q     <= ptr_q + 1'b1;
              after_q   <= ST_DATA;
            end
          endcase
        end else if (fall_i && ack_phase_q) begin
          oe_q        <= 1'b0;
          ack_phase_q <= 1'b0;
          bit_cnt_q   <= '0;
          state_q     <= after_q;
        end
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign wr_en_o   = we_q;

  // R7
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |=> !we_q);
  // R7
  wr_in_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> (state_q == ST_DATA));
  // R8
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> (ptr_q == ADDR_W'(wr_addr_q + 1'b1)));
  // R4
  ack_only_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> (state_q != ST_IDLE));
  // R3
  ack_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> $past(fall_i));
  // R2
  start_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == ST_DEV && !oe_q));
  // R2
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (state_q == ST_IDLE && !oe_q));
endmodule

// File: rtl/i2c_reg_writer.sv
module i2c_reg_writer #(
  parameter logic [6:0]  DEV_ADDR    = 7'b1000011,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [7:0]        reg_data_o,
  output logic              reg_we_o
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic start, stop, b_rise, b_fall, b_val;

  i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) scl_sync_i (
    .clk_i, .rst_ni, .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sda_sync_i (
    .clk_i, .rst_ni, .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  i2c_bus_cond cond_i (
    .clk_i, .rst_ni,
    .scl_lvl_i(scl_lvl), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_lvl_i(sda_lvl), .sda_rise_i(sda_rise), .sda_fall_i(sda_fall),
    .start_o(start), .stop_o(stop),
    .bit_rise_o(b_rise), .bit_fall_o(b_fall), .bit_val_o(b_val)
  );

  i2c_wr_fsm #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W)) fsm_i (
    .clk_i, .rst_ni,
    .start_i(start), .stop_i(stop), .rise_i(b_rise), .fall_i(b_fall),
    .bit_i(b_val),
    .sda_oe_o, .wr_addr_o(reg_addr_o), .wr_data_o(reg_data_o),
    .wr_en_o(reg_we_o)
  );
endmodule

// File: tb/i2c_reg_writer_tb_top.sv
`timescale 1ns/1ps
module i2c_reg_writer_tb_top;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_oe, reg_we;
  logic [7:0] reg_addr, reg_data;

  always #10 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_reg_writer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .reg_addr_o(reg_addr), .reg_data_o(reg_data),
    .reg_we_o(reg_we)
  );

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  logic [7:0] wa [0:31];
  logic [7:0] wd [0:31];

  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      if (wr_cnt < 32) begin
        wa[wr_cnt] = reg_addr;
        wd[wr_cnt] = reg_data;
      end
      wr_cnt = wr_cnt + 1;
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; hold(Q);
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b1; hold(Q);
    sda_m = 1'b1; hold(2*Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; hold(Q);
    scl_m = 1'b1; hold(2*Q);
    scl_m = 1'b0; hold(Q);
  endtask

  // returns the line level in the ninth pulse: 0 = acknowledged
  task automatic send_byte(input logic [7:0] b, output logic ack_lvl);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q);
    ack_lvl = sda_line;
    hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic t_reset();
    check("R1", "sda_oe after reset", {31'd0, sda_oe}, 32'd0);
    check("R1", "we after reset", {31'd0, reg_we}, 32'd0);
    check("R1", "addr after reset", {24'd0, reg_addr}, 32'd0);
    check("R1", "data after reset", {24'd0, reg_data}, 32'd0);
  endtask

  task automatic t_single();
    logic a;
    int n0 = wr_cnt;
    bus_start();
    send_byte(8'h86, a); check("R3", "dev ack", {31'd0, a}, 32'd0);
    check("R3", "oe released after 9th", {31'd0, sda_oe}, 32'd0);
    send_byte(8'h10, a); check("R6", "sub ack", {31'd0, a}, 32'd0);
    check("R6", "no write on sub", wr_cnt - n0, 32'd0);
    send_byte(8'h5A, a); check("R7", "data ack", {31'd0, a}, 32'd0);
    bus_stop();
    check("R7", "write count", wr_cnt - n0, 32'd1);
    check("R7", "write addr", {24'd0, wa[n0]}, 32'h10);
    check("R7", "write data", {24'd0, wd[n0]}, 32'h5A);
    check("R2", "oe after stop", {31'd0, sda_oe}, 32'd0);
  endtask

  task automatic t_burst_wrap();
    logic a;
    int n0 = wr_cnt;
    bus_start();
    send_byte(8'h86, a);
    send_byte(8'hFE, a);
    send_byte(8'h11, a); check("R7", "burst ack 1", {31'd0, a}, 32'd0);
    send_byte(8'h22, a); check("R7", "burst ack 2", {31'd0, a}, 32'd0);
    send_byte(8'h33, a); check("R7", "burst ack 3", {31'd0, a}, 32'd0);
    bus_stop();
    check("R8", "burst count", wr_cnt - n0, 32'd3);
    check("R8", "addr 0", {24'd0, wa[n0]}, 32'hFE);
    check("R8", "addr 1", {24'd0, wa[n0+1]}, 32'hFF);
    check("R8", "addr 2 wrapped", {24'd0, wa[n0+2]}, 32'h00);
    check("R7", "data 2", {24'd0, wd[n0+2]}, 32'h33);
  endtask

  task automatic t_wrong_addr();
    logic a;
    int n0 = wr_cnt;
    bus_start();
    send_byte(8'h88, a); check("R4", "foreign dev nack", {31'd0, a}, 32'd1);
    send_byte(8'h10, a); check("R4", "later byte nack", {31'd0, a}, 32'd1);
    send_byte(8'h77, a); check("R4", "data byte nack", {31'd0, a}, 32'd1);
    bus_stop();
    check("R4", "no write", wr_cnt - n0, 32'd0);
  endtask

  task automatic t_read_req();
    logic a;
    int n0 = wr_cnt;
    bus_start();
    send_byte(8'h87, a); check("R5", "read nack", {31'd0, a}, 32'd1);
    send_byte(8'h12, a); check("R5", "after read nack", {31'd0, a}, 32'd1);
    send_byte(8'h34, a);
    bus_stop();
    check("R5", "no write", wr_cnt - n0, 32'd0);
  endtask

  task automatic t_no_start();
    logic a;
    int n0 = wr_cnt;
    send_byte(8'h86, a); check("R2", "no ack without start", {31'd0, a}, 32'd1);
    send_byte(8'h44, a);
    send_byte(8'h55, a);
    bus_stop();
    check("R2", "no write without start", wr_cnt - n0, 32'd0);
  endtask

  task automatic t_rep_start();
    logic a;
    int n0 = wr_cnt;
    bus_start();
    send_byte(8'h86, a);
    send_byte(8'h20, a);
    send_byte(8'hA1, a);
    bus_start();
    send_byte(8'h86, a); check("R9", "dev ack after rep start", {31'd0, a}, 32'd0);
    send_byte(8'h40, a);
    send_byte(8'hB2, a);
    bus_stop();
    check("R9", "rep count", wr_cnt - n0, 32'd2);
    check("R9", "first addr", {24'd0, wa[n0]}, 32'h20);
    check("R9", "second addr", {24'd0, wa[n0+1]}, 32'h40);
    check("R9", "second data", {24'd0, wd[n0+1]}, 32'hB2);
  endtask

  task automatic t_partial_stop();
    logic a;
    int n0 = wr_cnt;
    bus_start();
    send_byte(8'h86, a);
    send_byte(8'h30, a);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_stop();
    check("R10", "partial byte dropped", wr_cnt - n0, 32'd0);
    check("R10", "oe idle", {31'd0, sda_oe}, 32'd0);
    bus_start();
    send_byte(8'h86, a);
    send_byte(8'h31, a);
    send_byte(8'hC3, a);
    bus_stop();
    check("R10", "next transfer writes", wr_cnt - n0, 32'd1);
    check("R10", "next transfer data", {24'd0, wd[n0]}, 32'hC3);
  endtask

  initial begin
    hold(5);
    t_reset();
    rst_n = 1'b1;
    hold(5);
    t_reset();
    t_single();
    t_burst_wrap();
    t_wrong_addr();
    t_read_req();
    t_no_start();
    t_rep_start();
    t_partial_stop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule